// File: doc/BRIEF.md
# Timestamped Debug Event Collector

The collector gathers single-cycle event pulses from a set of monitoring probes that share its clock. Pulses that arrive in the same cycle are all held in a pending register. A fixed-priority selector then releases them one per cycle. Each released event becomes a 32-bit record that holds an 8-bit source identifier and the value of a free-running timestamp counter. When the counter wraps, the wrap is itself raised as an event, and it outranks every probe.

Records go into a buffer only while a capture is in progress. Software-side control picks one probe as the trigger source and issues an arm pulse. Arming empties the buffer and the collector waits. The capture opens with the trigger probe's own record and runs until the buffer holds its full depth of records. Whenever the buffer is not empty, its contents drain as a stream of bytes under a valid/ready handshake toward a host link, one record at a time with the most significant byte first.

The control state machine has four states. **Idle** (code 0) is entered from reset. **Armed** (code 1) is entered from any state by the arm pulse. **Capturing** (code 2) is entered from Armed when the trigger probe's event is released. **Full** (code 3) is entered from Capturing on the write that brings the buffer to its depth. Full is left only by a new arm pulse. The arm transition takes precedence over every other transition.

Top module: `evt_collector`

## Requirements
- R1: After reset the status output is 0 (Idle), `out_valid` is low, and the timestamp counter starts at 0.
- R2: An event released while the status is Idle or Armed, other than the trigger event that starts a capture, is discarded and never reaches the output stream.
- R3: An arm pulse moves the status to 1 (Armed) in the next cycle and empties the buffer, so `out_valid` is low in the next cycle. This holds from any state.
- R4: In Armed, the release of the event of probe `trig_sel` moves the status to 2 (Capturing), and that event is the first record of the capture. `trig_sel` is read at run time. A value of `NUM_PROBES` or more never triggers.
- R5: Events that arrive in the same cycle are all recorded, one per cycle, with the lowest probe index first. Their timestamps rise by exactly 1 from one record to the next.
- R6: A new event on a probe whose earlier event is still pending merges with it, so only one record results.
- R7: A pending lower-priority event waits for as long as higher-priority events keep arriving, and it is recorded once that traffic stops. No aging is applied.
- R8: Each record is sent as four bytes. The first byte is the identifier (0 for a counter wrap, k+1 for probe k). The next three bytes are the 24-bit timestamp, most significant byte first. A counter narrower than 24 bits is zero-extended.
- R9: When the counter wraps to 0, a wrap event is raised. It has the highest priority, so it is recorded with identifier 0 and timestamp 0.
- R10: The write that brings the buffer to `DEPTH` records moves the status to 3 (Full). No later event is recorded until the next arm, even after the buffer drains.
- R11: `out_valid` is high whenever the buffer holds a record. While `out_ready` is low and no arm occurs, `out_valid` and `out_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Collector clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_evt | input | NUM_PROBES | One event pulse per probe; bit k is probe k |
| trig_sel | input | 4 | Index of the probe that starts a capture |
| arm | input | 1 | Pulse: clear the buffer and wait for the trigger |
| out_data | output | 8 | Current byte of the head record |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | The host link accepts the byte |
| state_o | output | 2 | 0 Idle, 1 Armed, 2 Capturing, 3 Full |

## Verification
The bench sends several probe pulses in a single cycle. A selector that dropped simultaneous events, or that reversed their priority, would leave out identifiers or emit them in the wrong order. A second probe pulse is sent while an earlier one is still waiting behind continuous higher-priority traffic: a design that counted pulses would emit a duplicate record, and one that let the low probe through early would break the starvation order. The bench also fills the buffer exactly to its depth and then pulses more probes, so that a design which kept writing, or which resumed capture after draining, would deliver more than `DEPTH` records. A long capture crosses a counter wrap and must show a record with identifier 0 and timestamp 0. Other checks cover an out-of-range trigger selection, a stall on `out_ready` and an arm pulse while data is waiting.

// File: rtl/evt_pkg.sv
package evt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_FULL  = 2'd3
    } cap_state_e;

    localparam int REC_W   = 32;
    localparam int ID_W    = 8;
    localparam int STAMP_W = 24;
    localparam int SEL_W   = 4;
endpackage

// File: rtl/evt_stamp_timer.sv
// Free-running timestamp counter; wrap_o is high in the cycle before it returns to zero.
module evt_stamp_timer #(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] stamp_o,
    output logic            wrap_o
);
    logic [TS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + TS_W'(1);
    end

    assign stamp_o = count_q;
    assign wrap_o  = &count_q;
endmodule

// File: rtl/evt_pend_arbiter.sv
// Holds one pending flag per source; releases the lowest-indexed flag each cycle.
module evt_pend_arbiter #(
    parameter int SRC = 17,
    localparam int IW = $clog2(SRC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] evt_in,
    output logic           grant_vld,
    output logic [IW-1:0]  grant_idx
);
    logic [SRC-1:0] pend_q;
    logic [SRC-1:0] release_mask;

    always_comb begin
        grant_idx = '0;
        for (int i = SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) grant_idx = IW'(i);
        end
    end

    assign grant_vld    = |pend_q;
    assign release_mask = grant_vld ? (SRC'(1) << grant_idx) : '0;

    // A repeated pulse on a still-pending source folds into the same flag.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~release_mask) | evt_in;
    end
endmodule

// File: rtl/evt_record_fifo.sv
// Circular record store; DEPTH must be a power of two.
module evt_record_fifo #(
    parameter int DEPTH = 512,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr, do_pop;

    assign do_wr  = wr  && (cnt_q != CW'(DEPTH));
    assign do_pop = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (do_wr && !clr) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr)  wptr_q <= wptr_q + AW'(1);
            if (do_pop) rptr_q <= rptr_q + AW'(1);
            cnt_q <= cnt_q + CW'(do_wr) - CW'(do_pop);
        end
    end

    assign rdata = mem[rptr_q];
    assign cnt   = cnt_q;
endmodule

// File: rtl/evt_collector.sv
module evt_collector
    import evt_pkg::*;
#(
    parameter int NUM_PROBES = 16,
    parameter int TS_W       = 24,
    parameter int DEPTH      = 512,
    localparam int SRC       = NUM_PROBES + 1,
    localparam int IW        = $clog2(SRC),
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PROBES-1:0] probe_evt,
    input  logic [SEL_W-1:0]      trig_sel,
    input  logic                  arm,
    output logic [7:0]            out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [1:0]            state_o
);
    cap_state_e      state_q, state_d;
    logic [TS_W-1:0] stamp;
    logic            wrap;
    logic            grant_vld;
    logic [IW-1:0]   grant_idx;
    logic [REC_W-1:0] rec, head;
    logic [CW-1:0]   fill;
    logic            wr_en, pop, hs, trig_hit, sel_ok, fills_up;
    logic [1:0]      byte_q;

    evt_stamp_timer #(.TS_W(TS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .stamp_o(stamp), .wrap_o(wrap)
    );

    // Source 0 is the counter wrap; source k+1 is probe k.
    evt_pend_arbiter #(.SRC(SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .evt_in({probe_evt, wrap}),
        .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    assign rec = {ID_W'(grant_idx), STAMP_W'(stamp)};

    evt_record_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(arm), .wr(wr_en), .wdata(rec),
        .pop(pop), .rdata(head), .cnt(fill)
    );

    assign sel_ok   = int'(trig_sel) < NUM_PROBES;
    assign trig_hit = grant_vld && sel_ok && (int'(grant_idx) == int'(trig_sel) + 1);
    assign fills_up = (fill + CW'(1) - CW'(pop)) == CW'(DEPTH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (trig_hit) state_d = fills_up ? ST_FULL : ST_CAPT;
                ST_CAPT:  if (grant_vld && fills_up) state_d = ST_FULL;
                ST_FULL:  state_d = ST_FULL;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        wr_en = 1'b0;
        if (!arm) begin
            unique case (state_q)
                ST_IDLE:  wr_en = 1'b0;
                ST_ARMED: wr_en = trig_hit;
                ST_CAPT:  wr_en = grant_vld;
                ST_FULL:  wr_en = 1'b0;
            endcase
        end
    end

    // Byte serializer, most significant byte first
    assign out_valid = (fill != '0);
    assign hs        = out_valid && out_ready;
    assign pop       = hs && (byte_q == 2'd3);

    always_ff @(posedge clk) begin
        if (!rst_n || arm) byte_q <= 2'd0;
        else if (hs)       byte_q <= byte_q + 2'd1;
    end

    always_comb begin
        unique case (byte_q)
            2'd0: out_data = head[31:24];
            2'd1: out_data = head[23:16];
            2'd2: out_data = head[15:8];
            2'd3: out_data = head[7:0];
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/evt_collector_chk.sv
module evt_collector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] state_o
);
    // R1: Idle is only reached from reset, so nothing can be offered there
    a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> !out_valid);

    // R3: arm always lands in Armed with an empty buffer
    a_r3_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state_o == 2'd1 && !out_valid));

    // R4: Capturing is only entered from Armed
    a_r4_capture_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && $past(state_o) != 2'd2) |-> $past(state_o) == 2'd1);

    // R10: Full is entered from Capturing (or on a depth-one trigger) and kept until arm
    a_r10_full_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) != 2'd3) |-> ($past(state_o) == 2'd2 || $past(state_o) == 2'd1));

    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !arm) |=> state_o == 2'd3);

    // R11: a stalled byte stays offered and unchanged
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !arm) |=> (out_valid && $stable(out_data)));
endmodule

bind evt_collector evt_collector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .state_o(state_o)
);

// File: tb/evt_collector_tb_top.sv
`timescale 1ns/1ps
module evt_collector_tb_top;
    localparam int NP = 4;
    localparam int TSW = 10;
    localparam int DEP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] probe_evt = '0;
    logic [3:0]    trig_sel = '0;
    logic          arm = 1'b0;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_valid;
    logic [1:0]    state_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [7:0] rxq[$];
    int ids[$];
    int tss[$];

    always #2.5 clk = ~clk;

    evt_collector #(.NUM_PROBES(NP), .TS_W(TSW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .probe_evt(probe_evt), .trig_sel(trig_sel),
        .arm(arm), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .state_o(state_o)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Bytes accepted at the next rising edge are captured mid-cycle.
    always @(negedge clk) if (rst_n && out_valid && out_ready) rxq.push_back(out_data);

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [NP-1:0] m);
        probe_evt = m; tick(1); probe_evt = '0;
    endtask

    task automatic do_arm(input int sel);
        trig_sel = 4'(sel); arm = 1'b1; tick(1); arm = 1'b0;
    endtask

    task automatic settle();
        while ((cyc % 1024) > 900) tick(1);
    endtask

    task automatic collect(input bit keep_wrap);
        ids.delete(); tss.delete();
        while (rxq.size() >= 4) begin
            int id, ts;
            id = rxq.pop_front();
            ts = rxq.pop_front();
            ts = (ts << 8) | rxq.pop_front();
            ts = (ts << 8) | rxq.pop_front();
            if (id != 0 || keep_wrap) begin ids.push_back(id); tss.push_back(ts); end
        end
    endtask

    task automatic t_reset();
        chk("R1", "state after reset", state_o, 0);
        chk("R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_idle_ignored();
        pulse(4'b1111); tick(5);
        chk("R2", "out_valid idle", out_valid, 0);
        chk("R2", "state idle", state_o, 0);
    endtask

    task automatic t_trigger();
        settle(); rxq.delete(); out_ready = 1'b1;
        do_arm(2);
        chk("R3", "state after arm", state_o, 1);
        pulse(4'b0010); tick(5);
        chk("R2", "armed non-trigger dropped", out_valid, 0);
        chk("R4", "still armed", state_o, 1);
        pulse(4'b0100); tick(3);
        chk("R4", "capturing", state_o, 2);
        tick(10); collect(0);
        chk("R4", "records after trigger", ids.size(), 1);
        if (ids.size() > 0) chk("R4", "first id is trigger", ids[0], 3);
    endtask

    task automatic t_simultaneous();
        settle(); rxq.delete();
        pulse(4'b1011); tick(20); collect(0);
        chk("R5", "record count", ids.size(), 3);
        if (ids.size() == 3) begin
            chk("R5", "order 0", ids[0], 1);
            chk("R5", "order 1", ids[1], 2);
            chk("R8", "order 2 id of probe 3", ids[2], 4);
            chk("R5", "stamp step a", tss[1] - tss[0], 1);
            chk("R5", "stamp step b", tss[2] - tss[1], 1);
        end
    endtask

    task automatic t_merge_starve();
        settle(); rxq.delete();
        probe_evt = 4'b1001; tick(1);
        probe_evt = 4'b0001; tick(1);
        probe_evt = 4'b1001; tick(1);
        probe_evt = 4'b0001; tick(2);
        probe_evt = '0; tick(30); collect(0);
        chk("R6", "records with merge", ids.size(), 6);
        if (ids.size() == 6) begin
            for (int i = 0; i < 5; i++) chk("R7", "high-priority first", ids[i], 1);
            chk("R7", "starved probe last", ids[5], 4);
        end
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        settle(); rxq.delete(); out_ready = 1'b0;
        pulse(4'b0100); tick(3);
        chk("R11", "valid when non-empty", out_valid, 1);
        d0 = out_data;
        chk("R8", "first byte is id", d0, 3);
        tick(4);
        chk("R11", "valid held in stall", out_valid, 1);
        chk("R11", "byte held in stall", out_data, d0);
        out_ready = 1'b1; tick(10); collect(0);
        chk("R11", "one record after stall", ids.size(), 1);
    endtask

    task automatic t_wrap();
        int found = 0;
        rxq.delete(); out_ready = 1'b1;
        tick(1100); collect(1);
        foreach (ids[i]) if (ids[i] == 0 && found == 0) begin
            found = 1;
            chk("R9", "wrap stamp", tss[i], 0);
        end
        chk("R9", "wrap record seen", found, 1);
    endtask

    task automatic t_bad_sel();
        settle(); rxq.delete();
        do_arm(5);
        pulse(4'b1111); tick(5);
        chk("R4", "out-of-range sel state", state_o, 1);
        chk("R4", "out-of-range sel valid", out_valid, 0);
    endtask

    task automatic t_full();
        settle(); rxq.delete(); out_ready = 1'b0;
        do_arm(1);
        chk("R3", "armed before fill", state_o, 1);
        pulse(4'b0010);
        probe_evt = 4'b0001; tick(7); probe_evt = '0; tick(3);
        chk("R10", "state full", state_o, 3);
        pulse(4'b1111); tick(5);
        chk("R10", "stays full", state_o, 3);
        out_ready = 1'b1; tick(4 * DEP + 5);
        pulse(4'b0010); tick(5);
        chk("R10", "full after drain", state_o, 3);
        chk("R10", "nothing after drain", out_valid, 0);
        collect(1);
        chk("R10", "record count at full", ids.size(), DEP);
        if (ids.size() > 0) chk("R10", "first id", ids[0], 2);
    endtask

    task automatic t_rearm();
        settle(); rxq.delete(); out_ready = 1'b0;
        do_arm(0);
        pulse(4'b0001); tick(3);
        chk("R3", "data waiting", out_valid, 1);
        do_arm(0);
        chk("R3", "arm empties buffer", out_valid, 0);
        chk("R3", "arm state", state_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(4); rst_n = 1'b1; tick(1);
        t_reset();
        t_idle_ignored();
        t_trigger();
        t_simultaneous();
        t_merge_starve();
        t_stall();
        t_wrap();
        t_bad_sel();
        t_full();
        t_rearm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule